// File: doc/BRIEF.md
# Receive Data Staging Buffer with Commit or Discard

This block sits between a serial-bus receive word decoder and the subaddress data memory of a remote terminal. It takes the data words of one incoming message and decides when they may reach memory. It has two modes, chosen by a configuration bit that a hardware reset clears.

In pass-through mode, which is the default, every received word is written to memory on the next clock at the next address. A message that ends in error therefore leaves memory holding a mix of old and new words. In staged mode, the words wait in a local buffer of up to 32 entries, which is one message of maximum length. They are written to memory as one burst only when the message ends without error. A message that ends in error is dropped, so valid data from the previous command is never partly overwritten.

A second configuration bit moves the data of broadcast messages to a separate memory region, placed a fixed offset above the message base. The mode and the region are fixed when a message starts. A start request that arrives during a burst waits until the burst has finished.

Top module: `rx_stage_commit`

## Requirements
- R1: After reset, `mem_we` and `busy` are low and both configuration bits are cleared. The block is therefore in pass-through mode until `cfg_stage` is written high.
- R2: In pass-through mode, a word accepted on clock edge k is written on edge k+1. The address is the effective base plus the word's position in the message, counted from 0.
- R3: In staged mode, no memory write takes place while the message is being received.
- R4: In staged mode, a message that ends with `msg_done` and without `msg_err` starts a burst. The burst writes one word per clock in arrival order, at addresses base, base+1, and so on. The first write is on the second edge after the edge that samples `msg_done`.
- R5: In staged mode, a message that ends with `msg_err` high writes nothing. The staged words are discarded, and the memory keeps its earlier contents.
- R6: The staging buffer holds at most DEPTH (32) words. Any further words of the same message are dropped and never written.
- R7: `busy` rises on the first edge after an error-free staged end and falls one cycle after the last burst write. Every write that does not follow an accepted word happens while `busy` is high.
- R8: A `msg_start` that arrives during a burst is held. It takes effect when the burst ends, with the base, broadcast flag and mode that were sampled at the request. The burst itself is not disturbed.
- R9: When `cfg_split` is 1 and `msg_bcast` is 1 at the start, the effective base is `msg_base` + BCAST_OFS. In every other case it is `msg_base`. This applies to both modes.
- R10: The mode is sampled when a message starts. A change of `cfg_stage` during the message does not change how that message is handled.
- R11: A staged message that ends without error but holds no words starts no burst. `busy` stays low and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| cfg_we | input | 1 | Loads the two configuration bits |
| cfg_stage | input | 1 | 1 = staged mode, 0 = pass-through mode |
| cfg_split | input | 1 | 1 = broadcast data goes to its own region |
| msg_start | input | 1 | Start of a new message |
| msg_base | input | ADDR_W | Base address of the message's data buffer |
| msg_bcast | input | 1 | The message is a broadcast |
| word_valid | input | 1 | A received data word is present |
| word_data | input | DATA_W | Received data word |
| msg_done | input | 1 | The message is complete |
| msg_err | input | 1 | The message ended in error |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | A commit burst is in progress |

## Verification
The assertions check on every cycle the following properties:
- No write occurs while a staged message is being received.
- Any write not caused by an accepted word falls inside `busy`.
- Consecutive burst writes step the address by one.
- The buffer count never exceeds its depth.
- Reset holds the outputs idle.

Only the bench scenarios can show the rest:
- the burst data and its order;
- the memory contents left by messages that ended in error;
- the broadcast region offset;
- the held start after a burst;
- the mode sampled at message start;
- the empty-message case.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   typedef enum logic [1:0] {
      RSC_IDLE  = 2'd0,
      RSC_RECV  = 2'd1,
      RSC_BURST = 2'd2
   } rsc_state_e;

   function automatic int rsc_cnt_w(input int depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/rsc_stage_buf.sv
module rsc_stage_buf #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 32,
   parameter bit CLEAR_STORE = 1'b0,
   localparam int CNT_W      = rsc_pkg::rsc_cnt_w(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic [CNT_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count
);

   logic [CNT_W-1:0]        cnt_q;
   logic                    push_ok;
   logic [DEPTH*DATA_W-1:0] flat;

   // A push is accepted only while there is room; later words are dropped
   assign push_ok = push && (cnt_q < CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (push_ok) cnt_q <= cnt_q + CNT_W'(1);
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [DATA_W-1:0] ent_q;
      if (CLEAR_STORE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 ent_q <= '0;
            else if (push_ok && cnt_q == CNT_W'(e))     ent_q <= push_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (push_ok && cnt_q == CNT_W'(e))          ent_q <= push_data;
         end
      end
      assign flat[e*DATA_W +: DATA_W] = ent_q;
   end

   assign rd_data = flat[rd_idx*DATA_W +: DATA_W];
   assign count   = cnt_q;

endmodule

// File: rtl/rsc_burst_seq.sv
module rsc_burst_seq #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] idx,
   output logic             last
);

   logic [CNT_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx_q <= '0;
      else if (load) idx_q <= '0;
      else if (run)  idx_q <= idx_q + CNT_W'(1);
   end

   assign idx  = idx_q;
   assign last = run && (idx_q == len - CNT_W'(1));

endmodule

// File: rtl/rx_stage_commit.sv
module rx_stage_commit #(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 11,
   parameter int DEPTH       = 32,
   parameter int BCAST_OFS   = 512,
   parameter bit CLEAR_STORE = 1'b0,
   localparam int CNT_W      = rsc_pkg::rsc_cnt_w(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_stage,
   input  logic              cfg_split,
   input  logic              msg_start,
   input  logic [ADDR_W-1:0] msg_base,
   input  logic              msg_bcast,
   input  logic              word_valid,
   input  logic [DATA_W-1:0] word_data,
   input  logic              msg_done,
   input  logic              msg_err,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy
);
   import rsc_pkg::*;

   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(BCAST_OFS);

   if (DEPTH < 1) begin : g_bad_depth
      $error("rx_stage_commit: DEPTH must be at least 1");
   end
   if (ADDR_W < $clog2(DEPTH)) begin : g_bad_addr
      $error("rx_stage_commit: ADDR_W too narrow for DEPTH");
   end
   if (BCAST_OFS < 0 || BCAST_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("rx_stage_commit: BCAST_OFS outside address space");
   end

   rsc_state_e        st_q;
   logic              stg_q, cfg_stage_q, cfg_split_q;
   logic [ADDR_W-1:0] base_q, off_q;
   logic              pend_q, pend_stg_q;
   logic [ADDR_W-1:0] pend_base_q;
   logic              we_q, bwe_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   logic [ADDR_W-1:0] live_base;
   logic              in_burst, rx, staged_rx;
   logic              launch_live, launch_pend, launch;
   logic              end_msg, good_end, word_ok, push, pt_wr, clr;
   logic [CNT_W-1:0]  stg_cnt, bidx;
   logic [DATA_W-1:0] rd_data;
   logic              burst_last;

   // Effective base: broadcast data moves up by a fixed offset when splitting
   assign live_base   = msg_base + ((cfg_split_q && msg_bcast) ? OFS : '0);
   assign in_burst    = (st_q == RSC_BURST);
   assign rx          = (st_q == RSC_RECV);
   assign staged_rx   = rx && stg_q;
   assign launch_live = msg_start && (!in_burst || burst_last);
   assign launch_pend = burst_last && pend_q && !msg_start;
   assign launch      = launch_live || launch_pend;
   assign end_msg     = rx && !msg_start && (msg_done || msg_err);
   assign good_end    = end_msg && stg_q && !msg_err && (stg_cnt != '0);
   assign word_ok     = rx && !msg_start && !msg_done && !msg_err && word_valid;
   assign push        = word_ok && stg_q;
   assign pt_wr       = word_ok && !stg_q;
   assign clr         = launch || (end_msg && !good_end) || burst_last;

   rsc_stage_buf #(
      .DATA_W      (DATA_W),
      .DEPTH       (DEPTH),
      .CLEAR_STORE (CLEAR_STORE)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (push),
      .push_data (word_data),
      .rd_idx    (bidx),
      .rd_data   (rd_data),
      .count     (stg_cnt)
   );

   rsc_burst_seq #(.CNT_W(CNT_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (good_end),
      .run   (in_burst),
      .len   (stg_cnt),
      .idx   (bidx),
      .last  (burst_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_stage_q <= 1'b0;
         cfg_split_q <= 1'b0;
      end else if (cfg_we) begin
         cfg_stage_q <= cfg_stage;
         cfg_split_q <= cfg_split;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RSC_IDLE;
         stg_q  <= 1'b0;
         base_q <= '0;
         off_q  <= '0;
      end else begin
         if (launch) begin
            st_q   <= RSC_RECV;
            stg_q  <= launch_live ? cfg_stage_q : pend_stg_q;
            base_q <= launch_live ? live_base : pend_base_q;
            off_q  <= '0;
         end else if (good_end) begin
            st_q <= RSC_BURST;
         end else if (end_msg || burst_last) begin
            st_q <= RSC_IDLE;
         end else if (pt_wr) begin
            off_q <= off_q + ADDR_W'(1);
         end
      end
   end

   // Start requests during a burst wait here until the burst ends
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_stg_q  <= 1'b0;
         pend_base_q <= '0;
      end else if (launch) begin
         pend_q <= 1'b0;
      end else if (in_burst && msg_start) begin
         pend_q      <= 1'b1;
         pend_stg_q  <= cfg_stage_q;
         pend_base_q <= live_base;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         bwe_q   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         we_q    <= pt_wr || in_burst;
         bwe_q   <= in_burst;
         addr_q  <= in_burst ? base_q + ADDR_W'(bidx) : base_q + off_q;
         wdata_q <= in_burst ? rd_data : word_data;
      end
   end

   assign mem_we    = we_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign busy      = in_burst || bwe_q;

endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
   parameter int DEPTH  = 32,
   parameter int CNT_W  = 6,
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              word_valid,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              busy,
   input logic              staged_rx,
   input logic [CNT_W-1:0]  stage_cnt
);

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         idle_in_reset_chk: assert (!mem_we && !busy)
            else $error("outputs active during reset");
      end
   end

   // R3
   no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      staged_rx && !busy |-> !mem_we);

   // R7
   burst_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && !$past(word_valid) |-> busy);

   // R4
   burst_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && busy && $past(mem_we && busy) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

   // R6
   stage_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_cnt <= CNT_W'(DEPTH));

endmodule

bind rx_stage_commit rsc_chk #(
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_valid (word_valid),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .busy       (busy),
   .staged_rx  (staged_rx),
   .stage_cnt  (stg_cnt)
);

// File: tb/tb_rx_stage_commit.sv
module tb_rx_stage_commit;

   localparam int DW = 16;
   localparam int AW = 8;
   localparam int OFS = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 0, cfg_stage = 0, cfg_split = 0;
   logic          msg_start = 0, msg_bcast = 0;
   logic [AW-1:0] msg_base = '0;
   logic          word_valid = 0;
   logic [DW-1:0] word_data = '0;
   logic          msg_done = 0, msg_err = 0;
   logic          mem_we, busy;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;

   int n_chk = 0;
   int n_fail = 0;
   int wr_cnt = 0;
   logic [DW-1:0] shadow [256] = '{default: '0};

   always #10 clk = ~clk;

   rx_stage_commit #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(32), .BCAST_OFS(OFS)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stage(cfg_stage), .cfg_split(cfg_split),
      .msg_start(msg_start), .msg_base(msg_base), .msg_bcast(msg_bcast),
      .word_valid(word_valid), .word_data(word_data), .msg_done(msg_done), .msg_err(msg_err),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy));

   always @(posedge clk) begin
      if (rst_n && mem_we) begin
         shadow[mem_addr] = mem_wdata;
         wr_cnt = wr_cnt + 1;
      end
   end

   typedef struct packed {
      logic       stg;
      logic       split;
      logic       bc;
      logic [7:0] base;
      logic [6:0] n;
      logic       err;
      logic [7:0] seed;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 1'b0, 8'd10, 7'd3,  1'b0, 8'hA1},
      '{1'b1, 1'b0, 1'b0, 8'd20, 7'd5,  1'b0, 8'hB2},
      '{1'b1, 1'b0, 1'b0, 8'd20, 7'd4,  1'b1, 8'hC3},
      '{1'b0, 1'b0, 1'b0, 8'd40, 7'd4,  1'b1, 8'hD4},
      '{1'b1, 1'b1, 1'b1, 8'd30, 7'd2,  1'b0, 8'hE5},
      '{1'b1, 1'b1, 1'b0, 8'd30, 7'd2,  1'b0, 8'hF6},
      '{1'b0, 1'b1, 1'b1, 8'd50, 7'd3,  1'b0, 8'h17},
      '{1'b1, 1'b0, 1'b0, 8'd60, 7'd32, 1'b0, 8'h28}
   };

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input bit stg, input bit split);
      @(negedge clk); cfg_we = 1; cfg_stage = stg; cfg_split = split;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic start_msg(input int base, input bit bc);
      @(negedge clk); msg_start = 1; msg_base = AW'(base); msg_bcast = bc;
      @(negedge clk); msg_start = 0; msg_bcast = 0;
   endtask

   task automatic send_word(input bit stg, input int eb, input int i, input logic [7:0] seed, input string tag);
      logic [DW-1:0] d = {seed, 8'(i)};
      @(negedge clk); word_valid = 1; word_data = d;
      @(negedge clk); word_valid = 0;
      if (!stg) begin
         chk(mem_we === 1'b1 && mem_addr == AW'(eb + i) && mem_wdata == d, tag, "passthrough write",
             {mem_we, mem_addr, mem_wdata}, {1'b1, AW'(eb + i), d});
      end else begin
         chk(mem_we === 1'b0, tag, "write during staged receive", mem_we, 0);
      end
   endtask

   task automatic finish(input bit stg, input bit err, input int n, input int eb, input logic [7:0] seed, input string tag);
      int nb = (n > 32) ? 32 : n;
      @(negedge clk); msg_done = 1; msg_err = err;
      @(negedge clk); msg_done = 0; msg_err = 0;
      if (stg && !err && n > 0) begin
         chk(busy === 1'b1 && mem_we === 1'b0, "R7", "busy at burst start", {busy, mem_we}, 2'b10);
         for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            chk(mem_we === 1'b1 && mem_addr == AW'(eb + i) && mem_wdata == {seed, 8'(i)}, tag,
                "burst write", {mem_we, mem_addr, mem_wdata}, {1'b1, AW'(eb + i), seed, 8'(i)});
         end
         @(negedge clk);
         chk(busy === 1'b0 && mem_we === 1'b0, "R7", "busy after burst", {busy, mem_we}, 0);
      end else if (stg) begin
         chk(busy === 1'b0, tag, "busy after staged end without burst", busy, 0);
      end
   endtask

   task automatic run_msg(input bit stg, input bit split, input bit bc, input int base, input int n,
                          input bit err, input logic [7:0] seed, input string tag);
      int eb = (base + ((split && bc) ? OFS : 0)) % 256;
      int nexp;
      set_cfg(stg, split);
      start_msg(base, bc);
      wr_cnt = 0;
      for (int i = 0; i < n; i++) send_word(stg, eb, i, seed, tag);
      finish(stg, err, n, eb, seed, tag);
      repeat (3) @(negedge clk);
      nexp = stg ? (err ? 0 : ((n > 32) ? 32 : n)) : n;
      chk(wr_cnt == nexp, tag, "write count", wr_cnt, nexp);
      for (int i = 0; i < nexp; i++)
         chk(shadow[(eb + i) % 256] == {seed, 8'(i)}, tag, "memory word", shadow[(eb + i) % 256], {seed, 8'(i)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: outputs idle under reset
      repeat (3) @(negedge clk);
      chk(mem_we === 1'b0 && busy === 1'b0, "R1", "idle in reset", {mem_we, busy}, 0);
      rst_n = 1;
      // R1: default mode is pass-through without any configuration write
      start_msg(5, 0);
      wr_cnt = 0;
      send_word(1'b0, 5, 0, 8'h55, "R1");
      finish(1'b0, 1'b0, 1, 5, 8'h55, "R1");

      // table of message scenarios (R2 R4 R5 R9)
      for (int k = 0; k < 8; k++) begin
         string tag;
         if (VECS[k].split) tag = "R9";
         else if (VECS[k].stg && VECS[k].err) tag = "R5";
         else if (VECS[k].stg) tag = "R4";
         else tag = "R2";
         run_msg(VECS[k].stg, VECS[k].split, VECS[k].bc, int'(VECS[k].base), int'(VECS[k].n),
                 VECS[k].err, VECS[k].seed, tag);
      end
      // R5: the staged error message left the earlier data in place
      chk(shadow[20] == 16'hB200 && shadow[23] == 16'hB203, "R5", "old data kept", shadow[23], 16'hB203);
      // R2: the pass-through error message wrote its words (mix of old and new)
      chk(shadow[43] == 16'hD403, "R2", "partial data written", shadow[43], 16'hD403);

      // R6: overflow drops the words after the 32nd
      run_msg(1'b1, 1'b0, 1'b0, 200, 34, 1'b0, 8'h3C, "R6");
      chk(shadow[232] == '0 && shadow[233] == '0, "R6", "no write past depth", shadow[232], 0);

      // R11: a staged message with no words
      run_msg(1'b1, 1'b0, 1'b0, 100, 0, 1'b0, 8'h11, "R11");

      // R10: a mode change during the message has no effect on it
      set_cfg(1'b1, 1'b0);
      start_msg(110, 0);
      wr_cnt = 0;
      @(negedge clk); cfg_we = 1; cfg_stage = 0;
      @(negedge clk); cfg_we = 0;
      send_word(1'b1, 110, 0, 8'h9A, "R10");
      send_word(1'b1, 110, 1, 8'h9A, "R10");
      finish(1'b1, 1'b0, 2, 110, 8'h9A, "R10");
      repeat (2) @(negedge clk);
      chk(wr_cnt == 2, "R10", "write count", wr_cnt, 2);

      // R8: a start during the burst waits for the burst to end
      set_cfg(1'b1, 1'b0);
      start_msg(70, 0);
      wr_cnt = 0;
      for (int i = 0; i < 3; i++) send_word(1'b1, 70, i, 8'h77, "R8");
      @(negedge clk); msg_done = 1;
      @(negedge clk); msg_done = 0; msg_start = 1; msg_base = 8'd90;
      @(negedge clk); msg_start = 0;
      while (busy) @(negedge clk);
      chk(shadow[70] == 16'h7700 && shadow[72] == 16'h7702, "R8", "first burst intact", shadow[72], 16'h7702);
      send_word(1'b1, 90, 0, 8'h88, "R8");
      send_word(1'b1, 90, 1, 8'h88, "R8");
      finish(1'b1, 1'b0, 2, 90, 8'h88, "R8");
      repeat (2) @(negedge clk);
      chk(wr_cnt == 5, "R8", "write count", wr_cnt, 5);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule